// File: doc/BRIEF.md
# PWM gate-drive timing logic

This block turns a pulse-width request into the two gate enables of a synchronous buck power stage. A free-running period counter marks the start of each switching cycle. A new cycle ends the low-side conduction (with a one-clock current-sample strobe), waits until the low-side gate is reported off, then raises the high-side gate. The high-side gate stays on until an external PWM comparator trips or a duty ceiling is reached. The block then waits for the high-side gate to be reported off and turns the low side back on.

Dead time is adaptive. Each gate may rise only after a feedback input reports the opposite gate off. A feedback that never arrives is treated as "off" after a fixed number of clocks, so the stage cannot lock up. The low side is held on for a guaranteed minimum time before the next cycle may start. If that minimum is not yet met when the period pulse arrives, the cycle start is deferred. Two inputs from the fault logic take priority. A force-off request turns both gates off. A force-low-side request parks the stage with the high side off and the low side on.

All timing is counted in system clocks. At 100 MHz the defaults give a 333-clock period, a 266-clock high-side ceiling, a 50-clock low-side minimum and a 20-clock feedback timeout.

Top module: `pwm_gate_timer`

## Requirements
- R1: A period pulse occurs every PERIOD_CYC (333) clocks. In steady operation each normal low-side end, and so each strobe, comes one clock after a period pulse, so strobes are exactly 333 clocks apart.
- R2: The high-side enable falls at the clock edge after the comparator input is sampled high while the high side is on. It never stays high for more than DUTY_MAX_CYC (266) consecutive clocks, even if the comparator never trips.
- R3: If the comparator input is high when a cycle would start, the high side does not turn on in that cycle (0 % duty), and the low side stays on without interruption.
- R4: A normally ending low-side period lasts at least LS_MIN_CYC (50) clocks. When the minimum is not met at the period pulse, the cycle start waits until it is met, giving exactly 50 clocks.
- R5: The two enables are never high together. A gate rises only after the feedback for the other gate (input high = gate sensed off) has been sampled high. With feedback that follows a gate off within two clocks, the both-off gap is 2 clocks.
- R6: If the awaited feedback stays low, the waiting gate rises after FB_TIMEOUT_CYC (20) clocks with both gates off.
- R7: The current-sample strobe is a one-clock pulse in the first clock the low side is off after a normal low-side end. It never appears otherwise: not while the low side is held on, and not when a force input ends the low side.
- R8: While the force-off input is high, both enables are low from the next clock on, whatever force-low-side does. After release, the low side returns once the high side is sensed off.
- R9: While the force-low-side input is high (and force-off low), the high side is low from the next clock. The low side turns on after the non-overlap wait and stays on across period pulses, with no strobe.
- R10: During reset all three outputs are low. One clock after reset is released, with the high side sensed off, the low-side enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_trip_i | input | 1 | PWM comparator output; high ends the high-side on-time |
| ls_off_fb_i | input | 1 | High when the low-side gate is sensed off |
| hs_off_fb_i | input | 1 | High when the high-side gate is sensed off |
| force_off_i | input | 1 | Fault request: both gates off |
| force_ls_i | input | 1 | Fault request: high side off, low side on |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| isense_strobe_o | output | 1 | One-clock strobe at the end of the low-side on-time |

## Verification
The non-overlap properties assume the gate feedback is honest. A feedback input reports "off" only after its gate enable has actually fallen, and the timeout covers the case where it never does. The bench models each feedback as the inverse of its gate enable and of that enable delayed by one clock, and it can hold both feedbacks stuck low to force the timeout path. The comparator is modelled from the high-side on-time, so a trip is raised only while the high side is on, except in the 0 % duty test, where it is held high on purpose. The force inputs are changed only on falling clock edges, and each is held for many clocks.

// File: rtl/pwm_gate_pkg.sv
// Package: shared types of the PWM gate-drive timing logic.
// Assumes nothing; holds the sequencer phase encoding only.
package pwm_gate_pkg;

    // Phases of one switching cycle plus the forced-off parking phase.
    typedef enum logic [2:0] {
        PH_OFF       = 3'd0,   // both gates off by fault request
        PH_DT_TO_LS  = 3'd1,   // both off, waiting for high side sensed off
        PH_LS        = 3'd2,   // low side conducting
        PH_DT_TO_HS  = 3'd3,   // both off, waiting for low side sensed off
        PH_HS        = 3'd4    // high side conducting
    } phase_t;

endpackage

// File: rtl/pwm_period_gen.sv
// Module: free-running switching-period counter.
// Produces a one-clock tick every PERIOD_CYC clocks; the first tick is
// in the PERIOD_CYC-th clock after reset. Assumes PERIOD_CYC >= 2.
module pwm_period_gen #(
    parameter int PERIOD_CYC = 333
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count 0..PERIOD_CYC-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/pwm_nonoverlap_guard.sv
// Module: adaptive dead-time guard for one gate.
// While wait_i is high it grants go_o as soon as the opposite gate's
// off feedback is high, or after TIMEOUT_CYC waiting clocks at the
// latest. Assumes wait_i stays high until go_o has been taken.
module pwm_nonoverlap_guard #(
    parameter int TIMEOUT_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_i,
    input  logic off_fb_i,
    output logic go_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] wait_cnt_q;

    // Count waiting clocks, cleared whenever no wait is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !wait_i) begin
            wait_cnt_q <= '0;
        end else if (wait_cnt_q != LAST) begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    assign go_o = wait_i && (off_fb_i || (wait_cnt_q == LAST));

endmodule

// File: rtl/pwm_gate_seq.sv
// Module: switching-cycle sequencer.
// Holds the set/reset cycle state: set by the period tick, reset by
// the comparator or the duty ceiling. Enforces the low-side minimum,
// emits the sample strobe and applies the fault overrides
// (force-off over force-low-side over normal operation).
// Assumes go_hs_i/go_ls_i come from guards driven by its wait outputs.
module pwm_gate_seq
    import pwm_gate_pkg::*;
#(
    parameter int DUTY_MAX_CYC = 266,
    parameter int LS_MIN_CYC   = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cmp_trip_i,
    input  logic force_off_i,
    input  logic force_ls_i,
    input  logic go_hs_i,
    input  logic go_ls_i,
    output logic wait_ls_off_o,
    output logic wait_hs_off_o,
    output logic hs_en_o,
    output logic ls_en_o,
    output logic strobe_o
);
    localparam int HW = $clog2(DUTY_MAX_CYC + 1);
    localparam int LW = $clog2(LS_MIN_CYC + 1);
    localparam logic [HW-1:0] HS_LAST = HW'(DUTY_MAX_CYC - 1);
    localparam logic [LW-1:0] LS_LAST = LW'(LS_MIN_CYC - 1);

    phase_t        ph_q, ph_d;
    logic          pend_q, pend_d;
    logic          strobe_q, strobe_d;
    logic [HW-1:0] hs_cnt_q;
    logic [LW-1:0] ls_cnt_q;
    logic          ls_done, hs_last, start;

    assign ls_done = (ls_cnt_q == LS_LAST);
    assign hs_last = (hs_cnt_q == HS_LAST);
    assign start   = pend_q || tick_i;

    // Next phase, pending-start latch and strobe decision.
    always_comb begin
        ph_d     = ph_q;
        pend_d   = pend_q || tick_i;
        strobe_d = 1'b0;
        case (ph_q)
            PH_OFF: begin
                ph_d = PH_DT_TO_LS;
            end
            PH_DT_TO_LS: begin
                if (go_ls_i) ph_d = PH_LS;
            end
            PH_LS: begin
                if (!force_ls_i && start && ls_done) begin
                    pend_d = 1'b0;
                    if (!cmp_trip_i) begin
                        ph_d     = PH_DT_TO_HS;
                        strobe_d = 1'b1;
                    end
                end
            end
            PH_DT_TO_HS: begin
                if (force_ls_i)   ph_d = PH_DT_TO_LS;
                else if (go_hs_i) ph_d = PH_HS;
            end
            PH_HS: begin
                if (force_ls_i || cmp_trip_i || hs_last) ph_d = PH_DT_TO_LS;
            end
            default: begin
                ph_d = PH_OFF;
            end
        endcase
        if (force_ls_i) begin
            pend_d = 1'b0;
        end
        if (force_off_i) begin
            ph_d     = PH_OFF;
            pend_d   = 1'b0;
            strobe_d = 1'b0;
        end
    end

    // State registers; reset parks in the wait before the low side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_DT_TO_LS;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            ph_q     <= ph_d;
            pend_q   <= pend_d;
            strobe_q <= strobe_d;
        end
    end

    // On-time counters, cleared outside their phase and saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ph_q != PH_HS) begin
            hs_cnt_q <= '0;
        end else if (!hs_last) begin
            hs_cnt_q <= hs_cnt_q + 1'b1;
        end
        if (!rst_n || ph_q != PH_LS) begin
            ls_cnt_q <= '0;
        end else if (!ls_done) begin
            ls_cnt_q <= ls_cnt_q + 1'b1;
        end
    end

    assign hs_en_o       = (ph_q == PH_HS);
    assign ls_en_o       = (ph_q == PH_LS);
    assign strobe_o      = strobe_q;
    assign wait_ls_off_o = (ph_q == PH_DT_TO_HS);
    assign wait_hs_off_o = (ph_q == PH_DT_TO_LS);

endmodule

// File: rtl/pwm_gate_timer.sv
// Module: top of the PWM gate-drive timing logic.
// Connects the period counter, the cycle sequencer and one dead-time
// guard per gate. Assumes the feedback inputs are synchronous to clk.
module pwm_gate_timer #(
    parameter int PERIOD_CYC     = 333,
    parameter int DUTY_MAX_CYC   = 266,
    parameter int LS_MIN_CYC     = 50,
    parameter int FB_TIMEOUT_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_trip_i,
    input  logic ls_off_fb_i,
    input  logic hs_off_fb_i,
    input  logic force_off_i,
    input  logic force_ls_i,
    output logic hs_en_o,
    output logic ls_en_o,
    output logic isense_strobe_o
);
    localparam int NGATE = 2;   // index 0: before high side, 1: before low side

    logic             tick;
    logic [NGATE-1:0] wait_v, fb_v, go_v;

    pwm_period_gen #(.PERIOD_CYC(PERIOD_CYC)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign fb_v = {hs_off_fb_i, ls_off_fb_i};

    // One adaptive dead-time guard per gate.
    for (genvar g = 0; g < NGATE; g++) begin : g_guard
        pwm_nonoverlap_guard #(.TIMEOUT_CYC(FB_TIMEOUT_CYC)) u_guard (
            .clk      (clk),
            .rst_n    (rst_n),
            .wait_i   (wait_v[g]),
            .off_fb_i (fb_v[g]),
            .go_o     (go_v[g])
        );
    end

    pwm_gate_seq #(
        .DUTY_MAX_CYC (DUTY_MAX_CYC),
        .LS_MIN_CYC   (LS_MIN_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .cmp_trip_i    (cmp_trip_i),
        .force_off_i   (force_off_i),
        .force_ls_i    (force_ls_i),
        .go_hs_i       (go_v[0]),
        .go_ls_i       (go_v[1]),
        .wait_ls_off_o (wait_v[0]),
        .wait_hs_off_o (wait_v[1]),
        .hs_en_o       (hs_en_o),
        .ls_en_o       (ls_en_o),
        .strobe_o      (isense_strobe_o)
    );

endmodule

// File: rtl/pwm_gate_timer_chk.sv
// Checker: temporal properties of the gate enables, bound to the top.
// Keeps its own run-length counters of the observed outputs.
module pwm_gate_timer_chk #(
    parameter int DUTY_MAX_CYC   = 266,
    parameter int LS_MIN_CYC     = 50,
    parameter int FB_TIMEOUT_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic ls_off_fb_i,
    input logic hs_off_fb_i,
    input logic force_off_i,
    input logic force_ls_i,
    input logic hs_en_o,
    input logic ls_en_o,
    input logic isense_strobe_o
);
    localparam int HW = $clog2(DUTY_MAX_CYC + 1);
    localparam int LW = $clog2(LS_MIN_CYC + 1);
    localparam int GW = $clog2(FB_TIMEOUT_CYC + 1);

    logic [HW-1:0] hs_run_q;
    logic [LW-1:0] ls_run_q;
    logic [GW-1:0] gap_q;

    // Saturating run lengths of high side on, low side on, both off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_run_q <= '0;
            ls_run_q <= '0;
            gap_q    <= '0;
        end else begin
            hs_run_q <= !hs_en_o ? '0 :
                        (hs_run_q == HW'(DUTY_MAX_CYC)) ? hs_run_q : hs_run_q + 1'b1;
            ls_run_q <= !ls_en_o ? '0 :
                        (ls_run_q == LW'(LS_MIN_CYC)) ? ls_run_q : ls_run_q + 1'b1;
            gap_q    <= (hs_en_o || ls_en_o) ? '0 :
                        (gap_q == GW'(FB_TIMEOUT_CYC)) ? gap_q : gap_q + 1'b1;
        end
    end

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o));

    // R5 R6
    hs_rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> ($past(ls_off_fb_i) || gap_q >= GW'(FB_TIMEOUT_CYC)));

    // R5 R6
    ls_rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en_o) |-> ($past(hs_off_fb_i) || gap_q >= GW'(FB_TIMEOUT_CYC)));

    // R2
    duty_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en_o |-> (hs_run_q < HW'(DUTY_MAX_CYC)));

    // R4
    ls_min_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ls_en_o) && !$past(force_off_i)) |-> (ls_run_q >= LW'(LS_MIN_CYC)));

    // R7
    strobe_at_ls_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isense_strobe_o |-> $fell(ls_en_o));

    // R8
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |=> (!hs_en_o && !ls_en_o));

    // R9
    force_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls_i && !force_off_i) |=> (!hs_en_o && !isense_strobe_o));

endmodule

bind pwm_gate_timer pwm_gate_timer_chk #(
    .DUTY_MAX_CYC   (DUTY_MAX_CYC),
    .LS_MIN_CYC     (LS_MIN_CYC),
    .FB_TIMEOUT_CYC (FB_TIMEOUT_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ls_off_fb_i     (ls_off_fb_i),
    .hs_off_fb_i     (hs_off_fb_i),
    .force_off_i     (force_off_i),
    .force_ls_i      (force_ls_i),
    .hs_en_o         (hs_en_o),
    .ls_en_o         (ls_en_o),
    .isense_strobe_o (isense_strobe_o)
);

// File: tb/test_pwm_gate_timer.sv
module test_pwm_gate_timer;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 333;
    localparam int DUTY_MAX   = 266;
    localparam int LS_MIN     = 50;
    localparam int FB_TO      = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_trip, ls_off_fb, hs_off_fb;
    logic force_off = 1'b0, force_ls = 1'b0;
    logic hs_en, ls_en, strobe;

    // bench plant model
    logic hs_d1 = 1'b0, ls_d1 = 1'b0;
    bit   fb_stuck = 1'b0, force_trip = 1'b0;
    int   trip_k = 100, hs_age = 0;

    // monitor controls and tallies
    bit   period_chk = 1'b1, ls_exact = 1'b0, force_win = 1'b0, done = 1'b0;
    int   dt_exp = 2;
    int   checks = 0, errors = 0;
    int   hs_falls = 0, hs_rises = 0, ls_falls = 0, strobes = 0, overlap_cnt = 0;
    int   hs_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_gate_timer i_pwm_gate_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmp_trip_i      (cmp_trip),
        .ls_off_fb_i     (ls_off_fb),
        .hs_off_fb_i     (hs_off_fb),
        .force_off_i     (force_off),
        .force_ls_i      (force_ls),
        .hs_en_o         (hs_en),
        .ls_en_o         (ls_en),
        .isense_strobe_o (strobe)
    );

    always @(posedge clk) begin
        hs_d1  <= hs_en;
        ls_d1  <= ls_en;
        hs_age <= hs_en ? hs_age + 1 : 0;
    end
    assign hs_off_fb = !fb_stuck && !hs_en && !hs_d1;
    assign ls_off_fb = !fb_stuck && !ls_en && !ls_d1;
    assign cmp_trip  = force_trip || (hs_en && (hs_age >= trip_k));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measures pulses and compares against the scoreboard
    int  hs_w = 0, ls_w = 0, gap = 0, cyc = 0, last_s = 0;
    bit  hs_p = 0, ls_p = 0, had_fall = 0, last_ok = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hs_w = 0; ls_w = 0; gap = 0; cyc = 0;
            hs_p = 0; ls_p = 0; had_fall = 0; last_ok = 0;
        end else begin
            cyc++;
            if (hs_en && ls_en) overlap_cnt++;
            if (!period_chk) last_ok = 0;
            if (hs_en) hs_w++;
            if (ls_en) ls_w++;
            if (hs_p && !hs_en) begin
                hs_falls++;
                had_fall = 1;
                if (hs_q.size() != 0) begin
                    int e;
                    e = hs_q.pop_front();
                    chk(hs_w == e, "R2 high-side on-time", hs_w, e);
                end
                hs_w = 0;
            end
            if (ls_p && !ls_en) begin
                ls_falls++;
                had_fall = 1;
                if (!force_win) begin
                    chk(ls_w >= LS_MIN, "R4 low-side minimum", ls_w, LS_MIN);
                    chk(strobe, "R7 strobe at low-side end", strobe, 1);
                end
                if (ls_exact) chk(ls_w == LS_MIN, "R4 deferred start", ls_w, LS_MIN);
                ls_w = 0;
            end
            if (strobe) begin
                strobes++;
                if (!(ls_p && !ls_en)) chk(1'b0, "R7 stray strobe", 1, 0);
                if (period_chk && last_ok) chk(cyc - last_s == PERIOD, "R1 strobe spacing", cyc - last_s, PERIOD);
                last_s  = cyc;
                last_ok = period_chk;
            end
            if ((hs_en && !hs_p) || (ls_en && !ls_p)) begin
                if (hs_en && !hs_p) hs_rises++;
                if (had_fall && dt_exp != 0)
                    chk(gap == dt_exp, (dt_exp == FB_TO) ? "R6 timeout dead time" : "R5 dead time", gap, dt_exp);
                gap = 0;
            end else if (!hs_en && !ls_en) begin
                gap++;
            end
            hs_p = hs_en;
            ls_p = ls_en;
        end
    end

    task automatic wait_falls(input int n);
        int target;
        target = hs_falls + n;
        while (hs_falls < target) @(negedge clk);
    endtask

    task automatic push(input int n, input int w);
        for (int i = 0; i < n; i++) hs_q.push_back(w);
    endtask

    task automatic wait_hs_high();
        while (!hs_en) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // driver
    initial begin
        int s0, r0, f0, bad;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!hs_en && !ls_en && !strobe, "R10 outputs low in reset", {hs_en, ls_en, strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ls_en && !hs_en, "R10 low side first after reset", {hs_en, ls_en}, 2'b01);

        // R2 comparator-terminated on-time, several trip points
        trip_k = 100; push(3, 101); wait_falls(3);
        trip_k = 1;   push(3, 2);   wait_falls(3);
        trip_k = 264; push(2, 265); wait_falls(2);
        trip_k = 265; push(2, DUTY_MAX); wait_falls(2);
        // R2 ceiling without any trip
        trip_k = 1000; push(2, DUTY_MAX); wait_falls(2);

        // R3 zero duty: comparator high at cycle start
        force_trip = 1'b1; period_chk = 1'b0;
        s0 = strobes; r0 = hs_rises;
        repeat (1200) @(negedge clk);
        chk(hs_rises == r0, "R3 no high-side pulse", hs_rises - r0, 0);
        chk(ls_en, "R3 low side held", ls_en, 1);
        chk(strobes == s0, "R7 no strobe while low side held", strobes - s0, 0);
        force_trip = 1'b0; trip_k = 50; push(2, 51); wait_falls(2);
        period_chk = 1'b1; push(2, 51); wait_falls(2);

        // R6 stuck feedback, R4 deferred start
        fb_stuck = 1'b1; dt_exp = 0; period_chk = 1'b0; trip_k = 1000;
        push(5, DUTY_MAX); wait_falls(2);
        ls_exact = 1'b1; dt_exp = FB_TO; wait_falls(3);
        ls_exact = 1'b0; fb_stuck = 1'b0; dt_exp = 0; trip_k = 100;
        push(3, 101); wait_falls(1);
        dt_exp = 2; wait_falls(2);
        period_chk = 1'b1; trip_k = 150; push(3, 151); wait_falls(3);

        // R8 force-off during the high side, with force-low-side overlapping
        wait_hs_high(); repeat (10) @(negedge clk);
        force_off = 1'b1; force_win = 1'b1; dt_exp = 0; period_chk = 1'b0;
        @(negedge clk);
        chk(!hs_en && !ls_en, "R8 both off next clock", {hs_en, ls_en}, 0);
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            if (i == 200) force_ls = 1'b1;
            if (i == 300) force_ls = 1'b0;
            @(negedge clk);
            if (hs_en || ls_en) bad++;
        end
        chk(bad == 0, "R8 both off while forced (priority over R9 input)", bad, 0);
        force_off = 1'b0;
        repeat (3) @(negedge clk);
        chk(ls_en && !hs_en, "R8 low side back after release", {hs_en, ls_en}, 2'b01);
        force_win = 1'b0; trip_k = 100; push(2, 101); wait_falls(2);
        dt_exp = 2;

        // R9 force-low-side during the high side
        wait_hs_high(); repeat (5) @(negedge clk);
        force_ls = 1'b1; force_win = 1'b1; dt_exp = 0;
        @(negedge clk);
        chk(!hs_en, "R9 high side off next clock", hs_en, 0);
        repeat (3) @(negedge clk);
        chk(ls_en, "R9 low side on after dead time", ls_en, 1);
        s0 = strobes; r0 = hs_rises; f0 = ls_falls;
        repeat (1000) @(negedge clk);
        chk(hs_rises == r0 && ls_falls == f0, "R9 parked across periods", hs_rises - r0 + ls_falls - f0, 0);
        chk(strobes == s0, "R9 no strobe while parked", strobes - s0, 0);
        force_ls = 1'b0; force_win = 1'b0;
        push(1, 101); wait_falls(1);
        dt_exp = 2; push(2, 101); wait_falls(2);

        chk(overlap_cnt == 0, "R5 never both on", overlap_cnt, 0);
        chk(hs_q.size() == 0, "R2 all expected pulses seen", hs_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule